// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address sequence of one memory burst. A read or write command pulses `load` with the starting column, the decoded burst-length code and the burst-order mode. From the next clock on, the block presents one column address per enabled clock. It flags the final location of a fixed-length burst so that a precharge request can be raised on that beat. When the burst ends, it pulses `done` for one enabled cycle.

Fixed-length bursts wrap inside the aligned group of columns whose size is the burst length. The order within the group is either sequential or interleaved. A full-page burst walks the whole 1024-column page, wraps from the top column back to column 0, and runs until it is terminated. A new command may restart the burst at any column on any cycle. A terminate strobe ends the burst early. All inputs are sampled on the rising clock edge. When clock enable is low, every register holds its value.

Top module: `burst_col_gen`

## Requirements
- R1: While `rst_n` is low, `valid`, `last` and `done` are 0 and `col` is 0.
- R2: `load` sampled high with `cke` high starts a burst. After that edge, `valid` is 1 and `col` equals the sampled `start_col`; this is beat 0.
- R3: With `order_ilv` = 0 and a fixed length L, beat k outputs the start column with its low log2(L) bits replaced by (start low bits + k) mod L. The upper bits are unchanged.
- R4: With `order_ilv` = 1 and a fixed length L, beat k outputs the start column with its low log2(L) bits replaced by (start low bits XOR k).
- R5: `len_code` selects the length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives a full page. The codes 4, 5 and 6 act as a length of 1.
- R6: `last` is 1 exactly on beat L-1 of a fixed-length burst while `valid` is 1. It is never 1 in a full-page burst.
- R7: After the edge that consumes the last beat, `valid` is 0 and `done` is 1 for one enabled cycle, then `done` returns to 0.
- R8: A full-page burst steps sequentially modulo 1024 and ignores `order_ilv`. It stays valid past 1024 beats, with column 1023 followed by column 0.
- R9: `term` sampled high during a burst (without `load`) makes `valid` 0 and `done` 1 after that edge. While idle, `term` has no effect.
- R10: `load` during a burst restarts the sequence at the new column with the new settings. It wins over `term` on the same edge and does not pulse `done`.
- R11: With `cke` low, `col`, `valid`, `last` and `done` hold their values, and `load` and `term` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable; low freezes the block |
| load | input | 1 | Command strobe that starts a burst |
| term | input | 1 | Burst terminate strobe |
| start_col | input | 10 | Starting column sampled with `load` |
| len_code | input | 3 | Burst length code |
| order_ilv | input | 1 | 0 = sequential order, 1 = interleaved order |
| col | output | 10 | Current column address |
| valid | output | 1 | `col` is a beat of the active burst |
| last | output | 1 | Final beat of a fixed-length burst |
| done | output | 1 | One-cycle pulse after a burst ends |

## Verification
The bench starts bursts close to group boundaries and near the top of the page. An adder that carried into the upper bits would leave the aligned group, and a full-page count that saturated at 1023 would not return to column 0. Interleaved starts that are not group-aligned expose XOR/add confusion. The reserved length codes and long full-page runs reveal a `last` flag that fires where it should not. Restart combined with terminate on the same edge, and load or terminate presented under a low clock enable, catch wrong priority and leaking enables.

// File: rtl/burst_pkg.sv
package burst_pkg;
  // Burst length code values
  localparam logic [2:0] LEN_1    = 3'd0;
  localparam logic [2:0] LEN_2    = 3'd1;
  localparam logic [2:0] LEN_4    = 3'd2;
  localparam logic [2:0] LEN_8    = 3'd3;
  localparam logic [2:0] LEN_PAGE = 3'd7;

  // Widest fixed burst is 8 beats -> 3 offset bits
  localparam int unsigned GRP_W = 3;

  typedef struct packed {
    logic             page;     // full-page burst
    logic             ilv;      // interleaved order
    logic [GRP_W-1:0] grp_mask; // length-1 for fixed bursts
  } burst_cfg_t;
endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
  import burst_pkg::*;
(
  input  logic [2:0]  len_code,
  input  logic        order_ilv,
  output burst_cfg_t  cfg
);
  always_comb begin
    cfg.page     = 1'b0;
    cfg.ilv      = order_ilv;
    cfg.grp_mask = '0;
    unique case (len_code)
      LEN_2:    cfg.grp_mask = 3'b001;
      LEN_4:    cfg.grp_mask = 3'b011;
      LEN_8:    cfg.grp_mask = 3'b111;
      LEN_PAGE: begin
        cfg.page = 1'b1;
        cfg.ilv  = 1'b0;
      end
      default:  cfg.grp_mask = 3'b000; // 1 beat, also reserved codes
    endcase
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic             load,
  input  logic             term,
  input  burst_cfg_t       cfg_q,
  output logic [COL_W-1:0] beat,
  output logic             valid,
  output logic             last,
  output logic             done
);
  localparam int unsigned PAD_W = COL_W - GRP_W;

  logic [COL_W-1:0] beat_d;
  logic             valid_d;
  logic             done_d;

  assign last = valid && !cfg_q.page && (beat == {{PAD_W{1'b0}}, cfg_q.grp_mask});

  always_comb begin
    beat_d  = beat;
    valid_d = valid;
    done_d  = 1'b0;
    if (load) begin
      beat_d  = '0;
      valid_d = 1'b1;
    end else if (valid && (term || last)) begin
      valid_d = 1'b0;
      done_d  = 1'b1;
    end else if (valid) begin
      beat_d  = beat + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat  <= '0;
      valid <= 1'b0;
      done  <= 1'b0;
    end else if (cke) begin
      beat  <= beat_d;
      valid <= valid_d;
      done  <= done_d;
    end
  end
endmodule

// File: rtl/burst_addr_calc.sv
module burst_addr_calc
  import burst_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic [COL_W-1:0] start_q,
  input  logic [COL_W-1:0] beat,
  input  burst_cfg_t       cfg_q,
  output logic [COL_W-1:0] col
);
  localparam int unsigned PAD_W = COL_W - GRP_W;

  logic [GRP_W-1:0] off_seq;
  logic [GRP_W-1:0] off_ilv;
  logic [GRP_W-1:0] off_sel;
  logic [COL_W-1:0] mask_ext;
  logic [COL_W-1:0] fixed_col;

  always_comb begin
    off_seq   = start_q[GRP_W-1:0] + beat[GRP_W-1:0];
    off_ilv   = start_q[GRP_W-1:0] ^ beat[GRP_W-1:0];
    off_sel   = cfg_q.ilv ? off_ilv : off_seq;
    mask_ext  = {{PAD_W{1'b0}}, cfg_q.grp_mask};
    fixed_col = (start_q & ~mask_ext) | ({{PAD_W{1'b0}}, off_sel} & mask_ext);
    col       = cfg_q.page ? (start_q + beat) : fixed_col;
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic             load,
  input  logic             term,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       len_code,
  input  logic             order_ilv,
  output logic [COL_W-1:0] col,
  output logic             valid,
  output logic             last,
  output logic             done
);
  burst_cfg_t       cfg_d;
  burst_cfg_t       cfg_q;
  logic [COL_W-1:0] start_q;
  logic [COL_W-1:0] beat;
  logic [COL_W-1:0] col_raw;

  burst_len_decode u_dec (
    .len_code  (len_code),
    .order_ilv (order_ilv),
    .cfg       (cfg_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      cfg_q   <= '0;
    end else if (cke && load) begin
      start_q <= start_col;
      cfg_q   <= cfg_d;
    end
  end

  burst_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .cke   (cke),
    .load  (load),
    .term  (term),
    .cfg_q (cfg_q),
    .beat  (beat),
    .valid (valid),
    .last  (last),
    .done  (done)
  );

  burst_addr_calc #(.COL_W(COL_W)) u_addr (
    .start_q (start_q),
    .beat    (beat),
    .cfg_q   (cfg_q),
    .col     (col_raw)
  );

  assign col = col_raw;
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int unsigned COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cke,
  input logic             load,
  input logic             term,
  input logic [COL_W-1:0] start_col,
  input logic [COL_W-1:0] col,
  input logic             valid,
  input logic             last,
  input logic             done
);
  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |-> (!valid && !last && !done && col == '0));

  p_load_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && load) |=> (valid && col == $past(start_col)));

  p_last_in_burst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> valid);

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cke) |=> !done);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !valid);

  p_term_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && term && !load && valid) |=> (!valid && done));

  p_restart_no_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && load) |=> !done);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> ($stable(col) && $stable(valid) && $stable(last) && $stable(done)));
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cke       (cke),
  .load      (load),
  .term      (term),
  .start_col (start_col),
  .col       (col),
  .valid     (valid),
  .last      (last),
  .done      (done)
);

// File: tb/burst_col_gen_tb.sv
`timescale 1ns/1ps
module burst_col_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cke, load, term, order_ilv;
  logic [9:0] start_col;
  logic [2:0] len_code;
  logic [9:0] col;
  logic       valid, last, done;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  burst_col_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .load(load), .term(term),
    .start_col(start_col), .len_code(len_code), .order_ilv(order_ilv),
    .col(col), .valid(valid), .last(last), .done(done)
  );

  typedef struct packed {
    logic [9:0]  st;
    logic [2:0]  code;
    logic        ilv;
    logic [10:0] k;
    logic [9:0]  exp_col;
    logic        exp_last;
    logic [3:0]  req;   // requirement tag number for the message
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{10'h005, 3'd2, 1'b0, 11'd0, 10'h005, 1'b0, 4'd3},
    '{10'h005, 3'd2, 1'b0, 11'd2, 10'h007, 1'b0, 4'd3},
    '{10'h005, 3'd2, 1'b0, 11'd3, 10'h004, 1'b1, 4'd3},
    '{10'h0FE, 3'd3, 1'b0, 11'd3, 10'h0F9, 1'b0, 4'd3},
    '{10'h0FE, 3'd3, 1'b1, 11'd3, 10'h0FD, 1'b0, 4'd4},
    '{10'h0FE, 3'd3, 1'b1, 11'd7, 10'h0F9, 1'b1, 4'd4},
    '{10'h3FF, 3'd1, 1'b1, 11'd1, 10'h3FE, 1'b1, 4'd4},
    '{10'h006, 3'd2, 1'b1, 11'd1, 10'h007, 1'b0, 4'd4},
    '{10'h123, 3'd0, 1'b0, 11'd0, 10'h123, 1'b1, 4'd5},
    '{10'h200, 3'd5, 1'b1, 11'd0, 10'h200, 1'b1, 4'd5},
    '{10'h3FE, 3'd7, 1'b0, 11'd3, 10'h001, 1'b0, 4'd8},
    '{10'h3FE, 3'd7, 1'b1, 11'd2, 10'h000, 1'b0, 4'd8}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic start(input logic [9:0] s, input logic [2:0] c, input logic i);
    load = 1'b1; start_col = s; len_code = c; order_ilv = i;
    cyc();
    load = 1'b0;
  endtask

  function automatic string rtag(input int n);
    return $sformatf("R%0d", n);
  endfunction

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    int lasts;
    rst_n = 1'b0; cke = 1'b1; load = 1'b0; term = 1'b0;
    start_col = '0; len_code = '0; order_ilv = 1'b0;
    cyc(); cyc();
    // R1 reset state
    chk(!valid && !last && !done && col == 10'h0, "R1", {valid, last, done, col}, 0);
    rst_n = 1'b1;
    cyc();

    // Table walk: R3, R4, R5, R6, R8
    for (int v = 0; v < NV; v++) begin
      start(VECS[v].st, VECS[v].code, VECS[v].ilv);
      for (int b = 0; b < int'(VECS[v].k); b++) cyc();
      chk(valid && col == VECS[v].exp_col, rtag(VECS[v].req), col, VECS[v].exp_col);
      chk(last == VECS[v].exp_last, "R6", last, VECS[v].exp_last);
      term = 1'b1; cyc(); term = 1'b0; cyc();
    end

    // R2 and R7: two-beat burst, natural end
    start(10'h010, 3'd1, 1'b0);
    chk(valid && col == 10'h010 && !last, "R2", col, 10'h010);
    cyc();
    chk(valid && col == 10'h011 && last, "R6", {last, col}, {1'b1, 10'h011});
    cyc();
    chk(!valid && done, "R7", {valid, done}, 2'b01);
    cyc();
    chk(!valid && !done, "R7", {valid, done}, 2'b00);

    // R9 terminate mid-burst, then while idle
    start(10'h040, 3'd7, 1'b0);
    cyc();
    term = 1'b1; cyc();
    chk(!valid && done, "R9", {valid, done}, 2'b01);
    cyc();
    chk(!valid && !done, "R9", {valid, done}, 2'b00);
    term = 1'b0;

    // R11 clock enable low holds and ignores load
    start(10'h100, 3'd7, 1'b0);
    cyc();
    cke = 1'b0; load = 1'b1; start_col = 10'h003; term = 1'b1;
    cyc(); cyc(); cyc();
    chk(valid && col == 10'h101 && !done, "R11", col, 10'h101);
    load = 1'b0; term = 1'b0; cke = 1'b1;
    cyc();
    chk(valid && col == 10'h102, "R11", col, 10'h102);

    // R10 restart with term on same edge
    load = 1'b1; term = 1'b1; start_col = 10'h2A0; len_code = 3'd2; order_ilv = 1'b0;
    cyc();
    load = 1'b0; term = 1'b0;
    chk(valid && col == 10'h2A0 && !done, "R10", {done, col}, 10'h2A0);
    cyc(); cyc(); cyc();
    chk(valid && col == 10'h2A3 && last, "R10", {last, col}, {1'b1, 10'h2A3});
    cyc();

    // R8 long full-page run past the wrap
    start(10'h000, 3'd7, 1'b1);
    lasts = 0;
    for (int b = 0; b < 1030; b++) begin
      if (last || !valid) lasts++;
      cyc();
    end
    chk(lasts == 0, "R8", lasts, 0);
    chk(valid && col == 10'h006, "R8", col, 10'h006);

    // R1 asynchronous reset mid-burst
    rst_n = 1'b0; #2;
    chk(!valid && !last && !done && col == 10'h0, "R1", {valid, col}, 0);
    cyc();
    rst_n = 1'b1;
    cyc();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule